// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one accepted burst command into the series of byte addresses that its data beats use. A command has a start address, a length code, a size code and a burst type. The block takes the command on a clock edge where `cmd_valid` and `cmd_ready` are both high. It then presents one address per beat and moves to the next address on each cycle where `beat_accept` is high. For every beat it also gives a byte-lane enable mask and a last-beat flag. Three burst types are supported: a constant address, a linear increment, and an increment that folds back inside an aligned container.

The controller has two states. **ST_IDLE** holds `cmd_ready` high. The transition *take_cmd* (`cmd_valid` high in ST_IDLE) moves it to **ST_BEAT**. ST_BEAT presents beats and has two transitions:
- *advance* (`beat_accept` high on a beat that is not the last) stays in ST_BEAT and moves to the next beat.
- *finish* (`beat_accept` high on the last beat) returns to ST_IDLE.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and just after it, `cmd_ready` is 1 and both `beat_valid` and `beat_last` are 0.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `beat_valid` is 1, `beat_addr` equals the start address, and `cmd_ready` is 0.
- R3: A burst has length code plus one beats. `beat_last` is 1 only on the final beat.
- R4: The bytes per beat are 2 to the power of the size code. With type 1 (increment), each beat after the first is the previous aligned address plus that byte count. For example, start 0x0, length 15, size 2 gives 0x0 to 0x3C in steps of 4.
- R5: An increment burst may start unaligned. Every beat after the first is aligned to the beat width. For example, start 0x1 with size 2 gives 0x4 as the second address.
- R6: With type 0 (fixed), every beat carries the start address.
- R7: With type 2 (wrap), the container is bytes-per-beat × beat count. The address increments and, on reaching the container's upper end, falls to the container base, which is the start address with its low log2(container) bits cleared. Legal wrap bursts have 2, 4, 8 or 16 beats and a start aligned to the beat width.
- R8: `beat_strb` bit i is 1 exactly when lane i is at least the address offset within the data bus and below the end of the beat-width window holding that offset.
- R9: Type 3 sequences as an increment burst, and `burst_err` is 1 on every beat of that burst. For any other type it is 0.
- R10: After the last beat is accepted, the next cycle has `cmd_ready` 1 and `beat_valid` 0.
- R11: `beat_accept` while idle has no effect. `cmd_valid` during a burst is ignored. While `beat_accept` is 0 the current beat holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_burst | input | 2 | 0 fixed, 1 increment, 2 wrap, 3 reserved |
| beat_accept | input | 1 | Current beat consumed |
| beat_valid | output | 1 | A beat address is presented |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_strb | output | DATA_BYTES | Byte-lane enables of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| burst_err | output | 1 | Current burst used the reserved type |

## Verification
The bench targets the points where address arithmetic most often goes wrong:
- **Unaligned increment start.** A design that just adds the width would give 0x5 instead of 0x4.
- **Wrap fold.** A wrap burst starting near the top of its container must fall to the base; a design without the fold runs past it.
- **Wrap with a narrow beat.** A design that sizes the container by beat count alone lands on the wrong base.
- **Single-beat burst.** This must raise `beat_last` at once.
- **Stalls, a fixed burst and the reserved type.** These catch address drift, a missing error flag, or a command taken while busy.

Lane masks are checked on unaligned beats, where a full-width mask would be wrong.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } state_e;
endpackage

// File: rtl/bag_next_addr.sv
module bag_next_addr
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        size,
    input  burst_e            btype,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] bytes;
    logic [ADDR_W-1:0] lane_mask;
    logic [ADDR_W-1:0] cont_mask;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        bytes     = ADDR_W'(1) << size;
        lane_mask = bytes - ADDR_W'(1);
        // container = bytes * beats; a power of two for legal wrap lengths
        cont_mask = (bytes * (ADDR_W'(len) + ADDR_W'(1))) - ADDR_W'(1);
        stepped   = (cur_addr & ~lane_mask) + bytes;
        unique case (btype)
            BT_FIXED: nxt_addr = cur_addr;
            BT_WRAP:  nxt_addr = (cur_addr & ~cont_mask) | (stepped & cont_mask);
            default:  nxt_addr = stepped;
        endcase
    end
endmodule

// File: rtl/bag_strobe.sv
module bag_strobe #(
    parameter int DATA_BYTES = 8,
    localparam int LANE_W = $clog2(DATA_BYTES)
) (
    input  logic [LANE_W-1:0]     offset,
    input  logic [2:0]            size,
    output logic [DATA_BYTES-1:0] strb
);
    logic [LANE_W:0] lo;
    logic [LANE_W:0] hi;
    logic [LANE_W:0] bytes;

    always_comb begin
        bytes = (LANE_W+1)'(1) << size;
        lo    = {1'b0, offset};
        hi    = (lo & ~(bytes - (LANE_W+1)'(1))) + bytes;
    end

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign strb[i] = ((LANE_W+1)'(i) >= lo) && ((LANE_W+1)'(i) < hi);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 4,
    parameter int DATA_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic [2:0]            cmd_size,
    input  logic [1:0]            cmd_burst,
    input  logic                  beat_accept,
    output logic                  beat_valid,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic [DATA_BYTES-1:0] beat_strb,
    output logic                  beat_last,
    output logic                  burst_err
);
    localparam int LANE_W = $clog2(DATA_BYTES);

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    cnt_q;
    logic [2:0]          size_q;
    burst_e              type_q;
    logic                err_q;
    logic [ADDR_W-1:0]   nxt_addr;
    logic [DATA_BYTES-1:0] lane_strb;
    logic                take_cmd;
    logic                at_last;

    assign take_cmd = (state_q == ST_IDLE) && cmd_valid;
    assign at_last  = (cnt_q == len_q);

    bag_next_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next (
        .cur_addr (addr_q),
        .len      (len_q),
        .size     (size_q),
        .btype    (type_q),
        .nxt_addr (nxt_addr)
    );

    bag_strobe #(.DATA_BYTES(DATA_BYTES)) u_strb (
        .offset (addr_q[LANE_W-1:0]),
        .size   (size_q),
        .strb   (lane_strb)
    );

    // next-state: take_cmd, advance, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_BEAT;
            ST_BEAT: if (beat_accept && at_last) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            size_q <= '0;
            type_q <= BT_INCR;
            err_q  <= 1'b0;
        end else if (take_cmd) begin
            addr_q <= cmd_addr;
            len_q  <= cmd_len;
            cnt_q  <= '0;
            size_q <= cmd_size;
            type_q <= burst_e'(cmd_burst);
            err_q  <= (cmd_burst == 2'd3);
        end else if ((state_q == ST_BEAT) && beat_accept && !at_last) begin
            addr_q <= nxt_addr;
            cnt_q  <= cnt_q + LEN_W'(1);
        end
    end

    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        beat_valid = (state_q == ST_BEAT);
        beat_addr  = addr_q;
        beat_strb  = beat_valid ? lane_strb : '0;
        beat_last  = beat_valid && at_last;
        burst_err  = beat_valid && err_q;
    end

    logic [ADDR_W-1:0] chk_mask;
    assign chk_mask = (ADDR_W'(1) << size_q) - ADDR_W'(1);

    p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (beat_valid && !cmd_ready && beat_addr == $past(cmd_addr)));

    p_incr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_accept && !beat_last && (type_q == BT_INCR || type_q == BT_RSVD))
        |=> ((beat_addr & chk_mask) == '0));

    p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_accept && !beat_last && type_q == BT_FIXED)
        |=> (beat_addr == $past(beat_addr)));

    p_strb_some_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_strb != '0));

    p_err_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err |-> beat_valid);

    p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last && beat_accept) |=> (cmd_ready && !beat_valid));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_accept) |=> (beat_valid && $stable(beat_addr) && $stable(beat_last)));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 32;
    localparam int LW = 4;
    localparam int DB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [2:0]    cmd_size = '0;
    logic [1:0]    cmd_burst = '0;
    logic          beat_accept = 1'b0;
    logic          beat_valid;
    logic [AW-1:0] beat_addr;
    logic [DB-1:0] beat_strb;
    logic          beat_last;
    logic          burst_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .DATA_BYTES(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
        .cmd_burst(cmd_burst), .beat_accept(beat_accept), .beat_valid(beat_valid),
        .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last),
        .burst_err(burst_err)
    );

    // fields: addr[31:0] len[3:0] size[2:0] type[1:0] noise[0]
    localparam int NV = 7;
    localparam logic [41:0] VEC [NV] = '{
        {32'h0000_0000, 4'd15, 3'd2, 2'd1, 1'b0},  // R4 example run
        {32'h0000_0001, 4'd3,  3'd2, 2'd1, 1'b0},  // R5 unaligned
        {32'h0000_0104, 4'd3,  3'd2, 2'd0, 1'b1},  // R6 fixed, R11 noise
        {32'h0000_0038, 4'd3,  3'd3, 2'd2, 1'b0},  // R7 fold after first beat
        {32'h0000_0006, 4'd7,  3'd1, 2'd2, 1'b0},  // R7 narrow wrap
        {32'h0000_0003, 4'd2,  3'd0, 2'd3, 1'b0},  // R9 reserved
        {32'h0000_0010, 4'd0,  3'd3, 2'd1, 1'b0}   // R3 single beat
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint exp_addr(longint st, int len, int sz, int ty, int n);
        longint b = 64'd1 << sz;
        longint cont, base;
        if (ty == 0) return st;
        if (ty == 2) begin
            cont = b * (len + 1);
            base = st - (st % cont);
            return base + ((st - base + n * b) % cont);
        end
        if (n == 0) return st;
        return (st / b) * b + n * b;
    endfunction

    function automatic logic [DB-1:0] exp_strb(longint a, int sz);
        logic [DB-1:0] m = '0;
        int off = int'(a % DB);
        int b = 1 << sz;
        int top = (off / b) * b + b;
        for (int i = 0; i < DB; i++) m[i] = (i >= off) && (i < top);
        return m;
    endfunction

    task automatic run_burst(input logic [41:0] v);
        longint st = longint'(v[41:10]);
        int len = int'(v[9:6]);
        int sz = int'(v[5:3]);
        int ty = int'(v[2:1]);
        bit noise = v[0];
        longint ea;
        @(negedge clk);
        chk("R2 ready before cmd", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_addr = v[41:10]; cmd_len = v[9:6];
        cmd_size = v[5:3]; cmd_burst = v[2:1];
        @(negedge clk);
        cmd_valid = noise;
        cmd_addr = v[41:10] ^ 32'h40;
        chk("R2 ready low in burst", 64'(cmd_ready), 64'd0);
        for (int n = 0; n <= len; n++) begin
            ea = exp_addr(st, len, sz, ty, n);
            chk("R2 beat_valid", 64'(beat_valid), 64'd1);
            chk("R4 R5 R6 R7 beat_addr", 64'(beat_addr), 64'(ea));
            chk("R8 beat_strb", 64'(beat_strb), 64'(exp_strb(ea, sz)));
            chk("R3 beat_last", 64'(beat_last), 64'(n == len));
            chk("R9 burst_err", 64'(burst_err), 64'(ty == 3));
            if (n == 1) begin
                @(negedge clk);
                chk("R11 stall holds addr", 64'(beat_addr), 64'(ea));
            end
            beat_accept = 1'b1;
            @(negedge clk);
            beat_accept = 1'b0;
        end
        cmd_valid = 1'b0;
        chk("R10 ready after last", 64'(cmd_ready), 64'd1);
        chk("R10 valid low after last", 64'(beat_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", 64'(cmd_ready), 64'd1);
        chk("R1 reset valid", 64'(beat_valid), 64'd0);
        chk("R1 reset last", 64'(beat_last), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 64'(cmd_ready), 64'd1);
        for (int k = 0; k < NV; k++) run_burst(VEC[k]);
        // R11: accept while idle has no effect
        beat_accept = 1'b1;
        repeat (2) @(negedge clk);
        beat_accept = 1'b0;
        chk("R11 idle accept ready", 64'(cmd_ready), 64'd1);
        chk("R11 idle accept valid", 64'(beat_valid), 64'd0);
        run_burst({32'h0000_0022, 4'd1, 3'd1, 2'd2, 1'b0});
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule